// File: doc/BRIEF.md
# PLL Clock Control Sequencer

This block is the digital controller that surrounds an on-chip phase-locked loop. It keeps a write-protected pair of registers. The control word holds a 4-bit frequency multiplier. The status word holds these fields:

- a 2-bit output divider select
- a lock flag
- a sticky limp-mode flag, meaning the reference clock has been lost
- a software-owned bit that disables missing-clock detection

The analog loop is not modelled. It is replaced by a lock counter that runs for a fixed number of oscillator cycles after every real change of the multiplier.

Two outputs drive the clock tree:

- a source select, which picks either the oscillator divided by two or the multiplied loop clock
- a divide-ratio code, which sets the final /4, /2 or /1 stage

The block sequences these outputs itself. While the loop is settling, the source select stays on the oscillator/2 path, and it moves to the loop clock only when the lock counter expires.

Software opens a protected-write window with one strobe and closes it with another. Inside the window it writes the multiplier while the divider is at /4, waits for lock, and then steps the divider. To reach /1 it must go through the /2 setting that uses code 2. The block refuses any write that breaks these ordering rules and flags it with a one-cycle error pulse.

Top module: `clkgen_seq`

## Requirements
- R1: After synchronous reset the register fields read as follows: control word 0, divider select 0, lock flag 1, limp flag 0, detect-disable bit 0. This makes stat_word 0x001. src_pll is 1, div_log2 is 2 and wr_err is 0.
- R2: A write takes effect only while the protected window is open. prot_open opens the window from the next cycle and prot_close shuts it from the next cycle; if both strobes arrive in the same cycle, the window ends up closed. A write outside the window changes nothing and raises no error.
- R3: A control write stores its low 4 data bits in ctrl_word[3:0]. A value above MULT_MAX is stored as MULT_MAX.
- R4: A control write made while the divider select is nonzero is rejected. All fields stay unchanged, and wr_err is high for exactly the one cycle after the write.
- R5: An accepted control write that changes the multiplier clears the lock flag (stat_word[0]) and src_pll in the cycle after the write. Both stay low for exactly LOCK_CYCLES cycles and then return to 1.
- R6: A control write of the value already held does not restart the lock counter and is not an error.
- R7: The divider select is at stat_word[8:7]. div_log2 is 2 for select 0, 1 for select 1 or 2, and 0 for select 3.
- R8: A status write that sets divider select 3 is accepted only if the current select is 2 or 3. Otherwise it is rejected: all fields stay unchanged and wr_err pulses. Moves to selects 0, 1 and 2 are always accepted.
- R9: A one-cycle pulse on limp_in sets the limp flag (stat_word[3]), which stays set until reset. While it is set, every control write is rejected with wr_err.
- R10: The detect-disable bit is stat_word[6]. Any accepted status write loads it from data bit 6.
- R11: If an accepted multiplier change arrives in the same cycle in which the lock counter would expire, the restart wins. The lock flag stays low and a fresh interval of LOCK_CYCLES cycles begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_open | input | 1 | Strobe that opens the protected-write window |
| prot_close | input | 1 | Strobe that closes the protected-write window |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 1 | Register selected: 0 for the control word, 1 for the status word |
| wr_data | input | 9 | Write data |
| limp_in | input | 1 | Loss-of-reference indication from the detector |
| ctrl_word | output | 9 | Control word, with the multiplier in bits 3:0 |
| stat_word | output | 9 | Status word: lock flag bit 0, limp flag bit 3, detect-disable bit 6, divider select bits 8:7 |
| src_pll | output | 1 | Clock source select: 1 for the loop clock, 0 for oscillator/2 |
| div_log2 | output | 2 | Final divider as a base-2 logarithm |
| wr_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
The lock counter expiring and a fresh multiplier change can fall in the same cycle, and the bench provokes this on purpose. It starts one change, waits exactly LOCK_CYCLES-1 edges, and presents a second, different value so that it is sampled on the edge where lock would otherwise return. It then counts the cycles with the lock flag low and expects a full new interval with no single-cycle rise in between. The divider ordering rule is also swept over all sixteen from/to select pairs, with acceptance predicted arithmetically.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int REG_W    = 9;
    localparam int MULT_W   = 4;
    localparam int LOCK_BIT = 0;
    localparam int LIMP_BIT = 3;
    localparam int OFF_BIT  = 6;
    localparam int DSEL_LSB = 7;

    typedef enum logic [1:0] {
        DS_QUARTER = 2'd0,
        DS_HALF_A  = 2'd1,
        DS_HALF_B  = 2'd2,
        DS_FULL    = 2'd3
    } dsel_e;

    typedef enum logic {
        WR_CTRL = 1'b0,
        WR_STAT = 1'b1
    } wsel_e;

    typedef struct packed {
        dsel_e dsel;
        logic  mcd_off;
        logic  limp;
    } stat_t;

    function automatic logic [MULT_W-1:0] sat_mult(input logic [MULT_W-1:0] v,
                                                   input logic [MULT_W-1:0] maxv);
        return (v > maxv) ? maxv : v;
    endfunction

    function automatic logic [1:0] div_log2_of(input dsel_e d);
        case (d)
            DS_QUARTER: return 2'd2;
            DS_FULL:    return 2'd0;
            default:    return 2'd1;
        endcase
    endfunction

    function automatic logic dsel_move_ok(input dsel_e from_d, input dsel_e to_d);
        return (to_d != DS_FULL) || (from_d == DS_HALF_B) || (from_d == DS_FULL);
    endfunction

endpackage

// File: rtl/clkgen_wprot.sv
module clkgen_wprot (
    input  logic clk,
    input  logic rst,
    input  logic open_i,
    input  logic close_i,
    output logic win_o
);

    always_ff @(posedge clk) begin
        if (rst)          win_o <= 1'b0;
        else if (close_i) win_o <= 1'b0;
        else if (open_i)  win_o <= 1'b1;
    end

    AST_WIN_SHUT: assert property (@(posedge clk) disable iff (rst)
        close_i |=> !win_o); // R2

    AST_WIN_OPEN: assert property (@(posedge clk) disable iff (rst)
        (open_i && !close_i) |=> win_o); // R2

endmodule

// File: rtl/clkgen_regs.sv
module clkgen_regs
    import clkgen_pkg::*;
#(
    parameter int MULT_MAX = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              limp_i,
    output logic [MULT_W-1:0] mult_o,
    output stat_t             stat_o,
    output logic              load_o,
    output logic              err_o
);

    localparam logic [MULT_W-1:0] MAX_V = MULT_W'(MULT_MAX);

    logic [MULT_W-1:0] req_mult;
    dsel_e             new_dsel;
    logic              ctrl_wr, stat_wr, ctrl_rej, stat_rej;
    logic              unused_bits;

    assign unused_bits = ^wr_data_i[5:4];

    always_comb begin
        req_mult = sat_mult(wr_data_i[MULT_W-1:0], MAX_V);
        new_dsel = dsel_e'(wr_data_i[DSEL_LSB +: 2]);
        ctrl_wr  = wr_en_i && (wr_sel_i == WR_CTRL);
        stat_wr  = wr_en_i && (wr_sel_i == WR_STAT);
        ctrl_rej = ctrl_wr && ((stat_o.dsel != DS_QUARTER) || stat_o.limp);
        stat_rej = stat_wr && !dsel_move_ok(stat_o.dsel, new_dsel);
        load_o   = ctrl_wr && !ctrl_rej && (req_mult != mult_o);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mult_o         <= '0;
            stat_o.dsel    <= DS_QUARTER;
            stat_o.mcd_off <= 1'b0;
            stat_o.limp    <= 1'b0;
            err_o          <= 1'b0;
        end else begin
            err_o <= ctrl_rej || stat_rej;
            if (load_o) mult_o <= req_mult;
            if (stat_wr && !stat_rej) begin
                stat_o.dsel    <= new_dsel;
                stat_o.mcd_off <= wr_data_i[OFF_BIT];
            end
            if (limp_i) stat_o.limp <= 1'b1;
        end
    end

    AST_MULT_RANGE: assert property (@(posedge clk) disable iff (rst)
        mult_o <= MAX_V); // R3

    AST_MULT_AT_QUARTER: assert property (@(posedge clk) disable iff (rst)
        !$stable(mult_o) |-> ($past(stat_o.dsel) == DS_QUARTER)); // R4

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        err_o |-> ($stable(mult_o) && $stable(stat_o.dsel))); // R4

    AST_FULL_FROM_HALF: assert property (@(posedge clk) disable iff (rst)
        ((stat_o.dsel == DS_FULL) && ($past(stat_o.dsel) != DS_FULL))
            |-> ($past(stat_o.dsel) == DS_HALF_B)); // R8

    AST_LIMP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        $past(stat_o.limp) |-> $stable(mult_o)); // R9

    AST_LIMP_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(stat_o.limp) |-> stat_o.limp); // R9

endmodule

// File: rtl/clkgen_lockctr.sv
module clkgen_lockctr #(
    parameter int LOCK_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic locked_o
);

    localparam int CNT_W = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            locked_o <= 1'b1;
        end else if (load_i) begin
            cnt_q    <= CNT_W'(LOCK_CYCLES - 1);
            locked_o <= 1'b0;
        end else if (!locked_o) begin
            if (cnt_q == '0) locked_o <= 1'b1;
            else             cnt_q    <= cnt_q - 1'b1;
        end
    end

    AST_LOAD_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !locked_o); // R5

    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> !$past(load_i)); // R11

endmodule

// File: rtl/clkgen_seq.sv
module clkgen_seq
    import clkgen_pkg::*;
#(
    parameter int MULT_MAX    = 5,
    parameter int LOCK_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prot_open,
    input  logic             prot_close,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             limp_in,
    output logic [REG_W-1:0] ctrl_word,
    output logic [REG_W-1:0] stat_word,
    output logic             src_pll,
    output logic [1:0]       div_log2,
    output logic             wr_err
);

    logic              win;
    logic              load;
    logic              locked;
    logic [MULT_W-1:0] mult;
    stat_t             stat;

    clkgen_wprot u_wprot (
        .clk     (clk),
        .rst     (rst),
        .open_i  (prot_open),
        .close_i (prot_close),
        .win_o   (win)
    );

    clkgen_regs #(.MULT_MAX(MULT_MAX)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en && win),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .limp_i    (limp_in),
        .mult_o    (mult),
        .stat_o    (stat),
        .load_o    (load),
        .err_o     (wr_err)
    );

    clkgen_lockctr #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .locked_o (locked)
    );

    always_comb begin
        ctrl_word               = '0;
        ctrl_word[MULT_W-1:0]   = mult;
        stat_word               = '0;
        stat_word[LOCK_BIT]     = locked;
        stat_word[LIMP_BIT]     = stat.limp;
        stat_word[OFF_BIT]      = stat.mcd_off;
        stat_word[DSEL_LSB +: 2] = stat.dsel;
        src_pll                 = locked;
        div_log2                = div_log2_of(stat.dsel);
    end

    AST_CLOSED_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (!win && !$past(win)) |-> ($stable(mult) && $stable(stat.dsel))); // R2

endmodule

// File: tb/clkgen_seq_bench.sv
module clkgen_seq_bench;

    localparam int L    = 8;
    localparam int MMAX = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prot_open = 1'b0, prot_close = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, limp_in = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] ctrl_word, stat_word;
    logic       src_pll, wr_err;
    logic [1:0] div_log2;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int exp_mult = 0;

    always #4 clk = ~clk;

    clkgen_seq #(.MULT_MAX(MMAX), .LOCK_CYCLES(L)) u_clkgen_seq (
        .clk(clk), .rst(rst), .prot_open(prot_open), .prot_close(prot_close),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .limp_in(limp_in),
        .ctrl_word(ctrl_word), .stat_word(stat_word), .src_pll(src_pll),
        .div_log2(div_log2), .wr_err(wr_err)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input int data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = 9'(data);
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic lock_run(input string tag);
        check({tag, " lock low k0"}, int'(stat_word[0]), 0);
        check({tag, " src osc k0"}, int'(src_pll), 0);
        for (int k = 1; k < L; k++) begin
            tick();
            check({tag, " lock low"}, int'(stat_word[0]), 0);
        end
        tick();
        check({tag, " lock back"}, int'(stat_word[0]), 1);
        check({tag, " src pll"}, int'(src_pll), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (4) tick();
        rst = 1'b0;
        // R1 reset state
        check("R1 ctrl", int'(ctrl_word), 0);
        check("R1 stat", int'(stat_word), 1);
        check("R1 src", int'(src_pll), 1);
        check("R1 div", int'(div_log2), 2);
        check("R1 err", int'(wr_err), 0);

        // R2 window closed, then simultaneous strobes
        wr(1'b0, 3);
        check("R2 closed ctrl", int'(ctrl_word), 0);
        check("R2 closed err", int'(wr_err), 0);
        prot_open = 1'b1; prot_close = 1'b1; tick(); prot_open = 1'b0; prot_close = 1'b0;
        wr(1'b0, 3);
        check("R2 both strobes ctrl", int'(ctrl_word), 0);
        prot_open = 1'b1; tick(); prot_open = 1'b0;
        wr(1'b0, 3);
        exp_mult = 3;
        check("R2 open ctrl", int'(ctrl_word), 3);
        lock_run("R5");

        // R6 same value
        wr(1'b0, 3);
        check("R6 no restart", int'(stat_word[0]), 1);
        check("R6 no err", int'(wr_err), 0);

        // R3 full sweep of the multiplier field
        for (int v = 0; v < 16; v++) begin
            wr(1'b0, v);
            exp_mult = (v > MMAX) ? MMAX : v;
            check("R3 sat", int'(ctrl_word), exp_mult);
            check("R3 err", int'(wr_err), 0);
        end
        repeat (L + 2) tick();

        // R11 restart in the expiry cycle
        wr(1'b0, 1);
        repeat (L - 1) tick();
        wr(1'b0, 2);
        exp_mult = 2;
        check("R11 ctrl", int'(ctrl_word), 2);
        lock_run("R11");

        // R7 R8 divider transitions
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                bit ok;
                int e;
                wr(1'b1, 0);
                if (a == 3) begin
                    wr(1'b1, 2 << 7);
                    wr(1'b1, 3 << 7);
                end else begin
                    wr(1'b1, a << 7);
                end
                wr(1'b1, b << 7);
                ok = !(b == 3 && a != 2 && a != 3);
                e  = ok ? b : a;
                check("R8 dsel", int'(stat_word[8:7]), e);
                check("R8 err", int'(wr_err), ok ? 0 : 1);
                check("R7 div", int'(div_log2), (e == 0) ? 2 : ((e == 3) ? 0 : 1));
            end
        end

        // R4 multiplier write with nonzero divider
        wr(1'b1, 1 << 7);
        wr(1'b0, 4);
        check("R4 err", int'(wr_err), 1);
        check("R4 ctrl", int'(ctrl_word), exp_mult);
        check("R4 lock", int'(stat_word[0]), 1);
        tick();
        check("R4 pulse", int'(wr_err), 0);
        wr(1'b1, 0);

        // R10 detect-disable bit
        wr(1'b1, 1 << 6);
        check("R10 set", int'(stat_word[6]), 1);
        check("R10 dsel", int'(stat_word[8:7]), 0);
        wr(1'b1, 0);
        check("R10 clr", int'(stat_word[6]), 0);

        // R9 limp mode
        limp_in = 1'b1; tick(); limp_in = 1'b0;
        check("R9 limp", int'(stat_word[3]), 1);
        tick();
        check("R9 sticky", int'(stat_word[3]), 1);
        wr(1'b0, 4);
        check("R9 err", int'(wr_err), 1);
        check("R9 ctrl", int'(ctrl_word), exp_mult);

        // R2 close
        prot_close = 1'b1; tick(); prot_close = 1'b0;
        wr(1'b1, 1 << 6);
        check("R2 closed stat", int'(stat_word[6]), 0);
        check("R2 closed no err", int'(wr_err), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule